// File: doc/BRIEF.md
# Increment-Decrement Counter Oscillator

This block is the controllable oscillator stage of an all-digital phase-locked loop. It is driven by a fast clock running at twice the product of the loop's centre frequency and the final division ratio. A toggle flip-flop divides that clock by two. The fast output is the clock's low phase gated by the inverse of the toggle state. With no requests, this gives one output pulse every second fast cycle. A divide-by-N stage then turns those pulses into a 50% duty square wave, and that square wave is the loop's feedback signal.

The loop filter nudges the phase of the oscillator with two request inputs. Its carry pulses go to the advance input. Its borrow pulses go to the retard input.

An advance request holds the toggle state low for one extra edge. This inserts one extra fast pulse, which is half a fast-output cycle gained. A retard request holds the toggle state high for one extra edge. This deletes one pulse, which is half a cycle lost.

Requests are taken on their rising edges. Each request waits until the toggle state allows it to act, and it is then used exactly once. An advance and a retard that are waiting together cancel out. With the default ratio of 8, a fast clock of 4.8 MHz gives a feedback frequency of 300 kHz. The loop is expected to hold lock over roughly 290 to 320 kHz.

Top module: `incdec_dco`

## Requirements
- R1: While no request is waiting, the toggle state inverts on every rising edge of `clk_fast`. `pulse_out` is therefore high in the low phase of every second fast cycle, which is half the fast clock frequency.
- R2: `pulse_out` equals (NOT `clk_fast`) AND (NOT toggle state). It is never high while `clk_fast` is high. It is high during the low phase of each cycle in which the toggle state is 0; each such cycle is called one output pulse.
- R3: A waiting advance request acts at the first rising edge at which the toggle state is 0. At that edge the state stays 0 instead of inverting, which inserts one extra output pulse. The request is then cleared.
- R4: A waiting retard request acts at the first rising edge at which the toggle state is 1. At that edge the state stays 1, which deletes one output pulse. The request is then cleared.
- R5: A request is registered on a 0-to-1 transition of `adv_req` or `ret_req` seen at a rising edge. A level that stays high registers once. Each registered request is used exactly once. A further transition while the same request is still waiting merges with it.
- R6: When an advance and a retard request are both waiting at an edge, both are discarded. The toggle state then inverts as in R1.
- R7: `div_out` inverts after every DIV_N/2 output pulses, counted in the cycle after each pulse. It is a 50% duty square wave with a period of DIV_N output pulses.
- R8: `rst_n` low clears everything at once: toggle state 0, `div_out` 0, pulse counter 0, no request waiting. After `rst_n` rises, the state stays cleared for SYNC_STAGES rising edges and starts moving at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, 2·N times the centre frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_req | input | 1 | Advance request from the loop filter (carry) |
| ret_req | input | 1 | Retard request from the loop filter (borrow) |
| pulse_out | output | 1 | Fast output: NOT clock AND NOT toggle state |
| div_out | output | 1 | Square wave after division by DIV_N |

## Verification
The bench targets four corner cases:
- **Request timing:** a request can arrive in either toggle phase. A design that acted on it at once, rather than at the matching phase, would flip the output polarity instead of shifting it by half a cycle.
- **Held request level:** a request input left high for many cycles must act once. An edge-blind design would keep inserting or deleting pulses, which slews the frequency.
- **Simultaneous requests:** an advance and a retard arriving together must cancel. A design that served one of them would leave a net phase step.
- **Divider count:** the bench counts pulses between `div_out` transitions. An off-by-one terminal count shows up directly as a wrong count.

// File: rtl/incdec_pkg.sv
package incdec_pkg;

  // What the toggle stage does at one rising edge.
  typedef enum logic [1:0] {
    ACT_FLIP    = 2'd0,  // normal inversion
    ACT_HOLD_LO = 2'd1,  // advance: keep state 0, extra pulse
    ACT_HOLD_HI = 2'd2,  // retard: keep state 1, pulse dropped
    ACT_CANCEL  = 2'd3   // both waiting: discard both, invert
  } tog_act_e;

  // Request channel indices.
  localparam int unsigned CH_ADV = 0;
  localparam int unsigned CH_RET = 1;
  localparam int unsigned N_CH   = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit <= 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/incdec_rst_sync.sv
module incdec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/incdec_req_latch.sv
module incdec_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic clear,
  output logic rise,
  output logic pend
);

  logic lvl_q;
  logic pend_q;
  logic pend_d;

  always_comb begin
    rise   = req_in & ~lvl_q;
    pend_d = (pend_q & ~clear) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= req_in;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/incdec_toggle_core.sv
module incdec_toggle_core
  import incdec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv_pend,
  input  logic     ret_pend,
  output logic     tog,
  output logic     adv_clr,
  output logic     ret_clr,
  output tog_act_e act
);

  logic tog_q;
  logic tog_d;

  always_comb begin
    act = ACT_FLIP;
    if (adv_pend && ret_pend)     act = ACT_CANCEL;
    else if (adv_pend && !tog_q)  act = ACT_HOLD_LO;
    else if (ret_pend &&  tog_q)  act = ACT_HOLD_HI;
  end

  always_comb begin
    unique case (act)
      ACT_HOLD_LO, ACT_HOLD_HI: tog_d = tog_q;
      default:                  tog_d = ~tog_q;
    endcase
    adv_clr = (act == ACT_HOLD_LO) || (act == ACT_CANCEL);
    ret_clr = (act == ACT_HOLD_HI) || (act == ACT_CANCEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign tog = tog_q;

endmodule

// File: rtl/incdec_divider.sv
module incdec_divider
  import incdec_pkg::*;
#(
  parameter int unsigned DIV_N = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            step_en,
  output logic [cnt_width(DIV_N/2)-1:0]   cnt,
  output logic                            sq
);

  localparam int unsigned HALF = DIV_N / 2;
  localparam int unsigned CW   = cnt_width(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sq_q, sq_d;
  logic          wrap;

  always_comb begin
    wrap  = step_en && (cnt_q == LAST);
    cnt_d = cnt_q;
    sq_d  = sq_q;
    if (step_en) begin
      if (wrap) begin
        cnt_d = '0;
        sq_d  = ~sq_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else if (step_en) begin
      cnt_q <= cnt_d;
      sq_q  <= sq_d;
    end
  end

  assign cnt = cnt_q;
  assign sq  = sq_q;

endmodule

// File: rtl/incdec_dco.sv
module incdec_dco
  import incdec_pkg::*;
#(
  parameter int unsigned DIV_N       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic adv_req,
  input  logic ret_req,
  output logic pulse_out,
  output logic div_out
);

  localparam int unsigned CW = cnt_width(DIV_N / 2);

  logic            rst_int_n;
  logic [N_CH-1:0] req_in;
  logic [N_CH-1:0] req_rise;
  logic [N_CH-1:0] req_pend;
  logic [N_CH-1:0] req_clr;
  logic            tog;
  tog_act_e        act;
  logic [CW-1:0]   div_cnt;

  incdec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk_fast),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  assign req_in[CH_ADV] = adv_req;
  assign req_in[CH_RET] = ret_req;

  for (genvar g = 0; g < N_CH; g++) begin : g_req
    incdec_req_latch u_lat (
      .clk    (clk_fast),
      .rst_n  (rst_int_n),
      .req_in (req_in[g]),
      .clear  (req_clr[g]),
      .rise   (req_rise[g]),
      .pend   (req_pend[g])
    );
  end

  incdec_toggle_core u_tog (
    .clk      (clk_fast),
    .rst_n    (rst_int_n),
    .adv_pend (req_pend[CH_ADV]),
    .ret_pend (req_pend[CH_RET]),
    .tog      (tog),
    .adv_clr  (req_clr[CH_ADV]),
    .ret_clr  (req_clr[CH_RET]),
    .act      (act)
  );

  incdec_divider #(.DIV_N(DIV_N)) u_div (
    .clk     (clk_fast),
    .rst_n   (rst_int_n),
    .step_en (~tog),
    .cnt     (div_cnt),
    .sq      (div_out)
  );

  assign pulse_out = ~clk_fast & ~tog;

endmodule

// File: rtl/incdec_dco_chk.sv
module incdec_dco_chk #(
  parameter int unsigned HALF = 4,
  parameter int unsigned CW   = 2
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          tog,
  input logic          adv_rise,
  input logic          ret_rise,
  input logic          adv_pend,
  input logic          ret_pend,
  input logic          div_q,
  input logic [CW-1:0] div_cnt
);

  p_free_flip_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!adv_pend && !ret_pend) |=> (tog != $past(tog)));

  p_adv_hold_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_pend && !ret_pend && !tog) |=> !tog);

  p_ret_hold_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ret_pend && !adv_pend && tog) |=> tog);

  p_rise_latch_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_rise || ret_rise) |=> (adv_pend || ret_pend));

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adv_pend && ret_pend && !adv_rise && !ret_rise) |=> (!adv_pend && !ret_pend));

  p_div_step_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (div_q != $past(div_q)) |-> !$past(tog));

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    int'(div_cnt) < HALF);

endmodule

bind incdec_dco incdec_dco_chk #(.HALF(DIV_N / 2), .CW(CW)) u_chk (
  .clk       (clk_fast),
  .rst_int_n (rst_int_n),
  .tog       (tog),
  .adv_rise  (req_rise[0]),
  .ret_rise  (req_rise[1]),
  .adv_pend  (req_pend[0]),
  .ret_pend  (req_pend[1]),
  .div_q     (div_out),
  .div_cnt   (div_cnt)
);

// File: tb/incdec_dco_tb.sv
module incdec_dco_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_N      = 8;
  localparam int HALF       = DIV_N / 2;

  logic clk = 1'b0;
  logic rst_n, adv_req, ret_req;
  logic pulse_out, div_out;

  int total = 0;
  int bad   = 0;
  string tag = "R8";
  bit div_cnt_on = 0;
  bit done = 0;

  // reference state, derived from the requirements
  logic       m_tog, m_ip, m_rp, m_iq, m_rq, m_div;
  int         m_cnt;
  logic [1:0] m_sync;

  incdec_dco #(.DIV_N(DIV_N), .SYNC_STAGES(2)) u_dut (
    .clk_fast  (clk),
    .rst_n     (rst_n),
    .adv_req   (adv_req),
    .ret_req   (ret_req),
    .pulse_out (pulse_out),
    .div_out   (div_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic ref_rise(input logic now, input logic last);
    return now & ~last;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 2'b00; m_tog = 0; m_ip = 0; m_rp = 0;
      m_iq = 0; m_rq = 0; m_div = 0; m_cnt = 0;
    end else begin
      if (m_sync[1]) begin
        logic ir, rr, ci, cr, nt;
        ir = ref_rise(adv_req, m_iq);
        rr = ref_rise(ret_req, m_rq);
        ci = 0; cr = 0; nt = ~m_tog;
        if (m_ip && m_rp) begin ci = 1; cr = 1; end          // R6
        else if (m_ip && !m_tog) begin nt = m_tog; ci = 1; end // R3
        else if (m_rp && m_tog) begin nt = m_tog; cr = 1; end  // R4
        if (!m_tog) begin                                      // R7
          if (m_cnt == HALF - 1) begin m_cnt = 0; m_div = ~m_div; end
          else m_cnt++;
        end
        m_ip = (m_ip & ~ci) | ir;                              // R5
        m_rp = (m_rp & ~cr) | rr;
        m_tog = nt;
        m_iq = adv_req;
        m_rq = ret_req;
      end
      m_sync = {m_sync[0], 1'b1};
    end
  end

  // low-phase checks
  initial begin : low_mon
    int pc = 0;
    logic pd = 0;
    bit seen = 0;
    forever begin
      @(negedge clk); #1;
      if (done) break;
      check(tag, "pulse_out low phase (R2)", pulse_out, ~m_tog);
      check(tag, "div_out (R7)", div_out, m_div);
      if (div_cnt_on) begin
        if (div_out !== pd) begin
          if (seen) begin
            total++;
            if (pc != HALF) begin
              bad++;
              $display("FAIL R7 pulses per div_out half period actual=%0d expected=%0d", pc, HALF);
            end
          end
          seen = 1; pc = 0;
        end
        if (pulse_out) pc++;
      end
      pd = div_out;
    end
  end

  // high-phase check: R2
  initial begin : high_mon
    forever begin
      @(posedge clk); #2;
      if (done) break;
      check("R2", "pulse_out high phase", pulse_out, 1'b0);
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      adv_req = 0; ret_req = 0;
    end
  endtask

  task automatic drive(input logic a, input logic r);
    @(negedge clk); #2;
    adv_req = a; ret_req = r;
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 0; adv_req = 0; ret_req = 0;
    tag = "R8";
    repeat (3) @(negedge clk);
    #1;
    check("R8", "reset div_out", div_out, 1'b0);
    check("R8", "reset pulse_out low phase", pulse_out, 1'b1);
    #1 rst_n = 1;
    idle(5);

    tag = "R1";
    idle(20);

    tag = "R3";
    for (int k = 0; k < 4; k++) begin
      drive(1, 0);
      idle(5 + k);
    end

    tag = "R4";
    for (int k = 0; k < 4; k++) begin
      drive(0, 1);
      idle(5 + k);
    end

    tag = "R6";
    for (int k = 0; k < 3; k++) begin
      drive(1, 1);
      idle(6 + k);
    end

    tag = "R5";
    for (int i = 0; i < 12; i++) drive(1, 0);
    idle(6);
    for (int i = 0; i < 12; i++) drive(0, 1);
    idle(6);

    tag = "R7";
    div_cnt_on = 1;
    idle(60);
    div_cnt_on = 0;

    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      int v;
      v = $urandom_range(0, 9);
      drive(v == 0 || v == 2 ? ~adv_req : adv_req,
            v == 1 || v == 2 ? ~ret_req : ret_req);
    end
    idle(10);

    done = 1;
    #(CLK_PERIOD);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule